// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Frame Parser

This block is the slave side of a two-wire serial link that controls a bank of digital potentiometers. It samples the clock and data lines with the system clock and finds the start and stop conditions on the bus. It collects the bytes of each frame, acknowledges them, and turns each complete command into a single-cycle strobe for a separate register unit. The strobe carries the opcode, the register selector, the potentiometer selector and the data byte. For a read, the block shifts a byte supplied by the register unit back out on the data line. The data line is open drain: the block only ever pulls it low.

A frame opens with an identity byte: the fixed family nibble `0101` in bits 7:4, and the strapped hardware address in bits 3:0. Next comes an instruction byte: opcode in bits 7:4, register selector in bits 3:2, potentiometer selector in bits 1:0, sent MSB first. Transfer opcodes end after this byte. Read and write opcodes carry one more data byte.

The step opcode switches the block into a streaming mode. After the instruction acknowledge, the block stops framing bytes and treats every clock pulse as one wiper step. The direction of each step comes from the data level during that pulse. The mode lasts until the next stop or repeated start.

Top module: `potbus_frame_parser`

## Requirements
- R1: A start condition (data falls while clock is high) seen at any point, including mid-byte or in step mode, drops the frame in progress. Parsing then restarts at the identity byte. A stop condition (data rises while clock is high) returns the block to idle.
- R2: The identity byte is acknowledged only when bits 7:4 equal `0101` and bits 3:0 equal `dev_addr`. When it is not acknowledged, the block stays silent and issues no strobe until the next start.
- R3: Defined opcodes are: `1101`, `1110`, `0001`, `1000` (transfers); `1010`, `1100` (writes); `1001`, `1011` (reads); `0010` (step). Any other opcode gets no acknowledge and no strobe.
- R4: A transfer opcode produces one `cmd_valid` pulse at the end of the instruction acknowledge. `cmd_opcode`, `cmd_reg` and `cmd_pot` come from instruction bits 7:4, 3:2 and 1:0.
- R5: A write opcode has its data byte acknowledged. It then produces one `cmd_valid` pulse with `cmd_data` equal to that byte.
- R6: A read opcode samples `rd_data` on the clock falling edge that ends the instruction acknowledge, and pulses `cmd_valid`. It then returns that byte MSB first: the line is pulled low for 0 bits and released for 1 bits.
- R7: In step mode, each clock pulse produces one `step_valid` pulse after the clock falls. `step_up` is 1 when data was high during the pulse and 0 when it was low. Step mode issues no `cmd_valid`.
- R8: A clock pulse that ends in a start or stop condition is not counted as a step.
- R9: `sda_oe` is asserted only during an acknowledge bit or a zero read-data bit. It only becomes asserted after a clock falling edge, and it is low after any stop.
- R10: After reset, `sda_oe`, `cmd_valid` and `step_valid` are low.
- R11: The block does not drive the line during the master's acknowledge slot that follows read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 4 | Strapped hardware address compared with identity bits 3:0 |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| rd_data | input | 8 | Read-back byte from the register unit |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 4 | Opcode of the current instruction |
| cmd_reg | output | 2 | Register selector |
| cmd_pot | output | 2 | Potentiometer selector |
| cmd_data | output | 8 | Write data (read byte for reads, zero for transfers) |
| step_valid | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 toward the high terminal |

## Verification
The bench goes after clock pulses that end in a repeated start or a stop while step mode is active. A parser that counted steps on the rising clock edge would report one step too many there. It also aborts a frame in the middle of a byte and sends a new one at once. A parser that kept its bit count would misread the new identity byte and refuse it. Undefined opcodes, a wrong identity nibble and a wrong hardware address are mixed into random frames. A block that acknowledged any of them, or strobed on them, would show extra acknowledges or extra commands. Read-back bytes with both 0 and 1 bits check that 1 bits are released rather than driven, and that the master's acknowledge slot stays free.

// File: rtl/potbus_pkg.sv
package potbus_pkg;

    localparam int BYTE_W = 8;
    localparam int OPC_W  = 4;
    localparam int SEL_W  = 2;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int IDX_W  = 2;

    localparam logic [OPC_W-1:0] OPC_DR2W      = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_W2DR      = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_GANG_DR2W = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_GANG_W2DR = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_WR_W      = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_WR_DR     = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_RD_W      = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_RD_DR     = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_STEP      = 4'b0010;

    typedef enum logic [2:0] {
        K_BAD, K_XFER, K_WRITE, K_READ, K_STEP
    } op_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_ACK_SETUP, PH_ACK, PH_TX, PH_STEP, PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [SEL_W-1:0] reg_sel;
        logic [SEL_W-1:0] pot_sel;
    } instr_t;

    function automatic op_kind_e classify(input logic [OPC_W-1:0] op);
        case (op)
            OPC_DR2W, OPC_W2DR, OPC_GANG_DR2W, OPC_GANG_W2DR: return K_XFER;
            OPC_WR_W, OPC_WR_DR:                              return K_WRITE;
            OPC_RD_W, OPC_RD_DR:                              return K_READ;
            OPC_STEP:                                         return K_STEP;
            default:                                          return K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/potbus_line_sync.sv
module potbus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/potbus_tx_shift.sv
module potbus_tx_shift
    import potbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-2:0] load_tail,
    input  logic              advance,
    output logic              next_bit,
    output logic              last_bit
);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] sh;
    logic [BIT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= load_tail;
            cnt <= '0;
        end else if (advance) begin
            sh  <= {sh[BYTE_W-3:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    assign next_bit = sh[BYTE_W-2];
    assign last_bit = (cnt == LAST);

endmodule

// File: rtl/potbus_frame_parser.sv
module potbus_frame_parser
    import potbus_pkg::*;
#(
    parameter logic [3:0] FAMILY_ID   = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        dev_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic [SEL_W-1:0]  cmd_reg,
    output logic [SEL_W-1:0]  cmd_pot,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              step_valid,
    output logic              step_up
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

    potbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    phase_e            phase;
    logic [BIT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_idx;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] rx_next;
    instr_t            instr;
    op_kind_e          instr_kind;
    logic              ack_ok;
    logic              accept_now;
    logic              step_armed;
    logic              step_dir;
    logic              tx_load, tx_adv, tx_next, tx_last;

    assign rx_next    = {rx_sh[BYTE_W-2:0], sda_lvl};
    assign instr_kind = classify(instr.opcode);

    always_comb begin
        case (byte_idx)
            2'd0:    accept_now = (rx_next[7:4] == FAMILY_ID) && (rx_next[3:0] == dev_addr);
            2'd1:    accept_now = (classify(rx_next[7:4]) != K_BAD);
            default: accept_now = 1'b1;
        endcase
    end

    assign tx_load = (phase == PH_ACK) && scl_fall && (byte_idx == 2'd1) && (instr_kind == K_READ);
    assign tx_adv  = (phase == PH_TX) && scl_fall;

    potbus_tx_shift u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_tail (rd_data[BYTE_W-2:0]),
        .advance   (tx_adv),
        .next_bit  (tx_next),
        .last_bit  (tx_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            rx_sh      <= '0;
            instr      <= '0;
            ack_ok     <= 1'b0;
            sda_oe     <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_data   <= '0;
            step_valid <= 1'b0;
            step_up    <= 1'b0;
            step_armed <= 1'b0;
            step_dir   <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            step_valid <= 1'b0;
            if (bus_start) begin
                phase      <= PH_RX;
                bit_cnt    <= '0;
                byte_idx   <= '0;
                sda_oe     <= 1'b0;
                step_armed <= 1'b0;
            end else if (bus_stop) begin
                phase      <= PH_IDLE;
                sda_oe     <= 1'b0;
                step_armed <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                phase  <= PH_ACK_SETUP;
                                ack_ok <= accept_now;
                                if (byte_idx == 2'd1) instr <= rx_next;
                            end
                        end
                    end
                    PH_ACK_SETUP: begin
                        if (scl_fall) begin
                            if (ack_ok) begin
                                sda_oe <= 1'b1;
                                phase  <= PH_ACK;
                            end else begin
                                phase  <= PH_HOLD;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            case (byte_idx)
                                2'd0: begin
                                    byte_idx <= 2'd1;
                                    phase    <= PH_RX;
                                end
                                2'd1: begin
                                    case (instr_kind)
                                        K_XFER: begin
                                            cmd_valid <= 1'b1;
                                            cmd_data  <= '0;
                                            phase     <= PH_HOLD;
                                        end
                                        K_WRITE: begin
                                            byte_idx <= 2'd2;
                                            phase    <= PH_RX;
                                        end
                                        K_READ: begin
                                            cmd_valid <= 1'b1;
                                            cmd_data  <= rd_data;
                                            sda_oe    <= ~rd_data[BYTE_W-1];
                                            phase     <= PH_TX;
                                        end
                                        K_STEP:  phase <= PH_STEP;
                                        default: phase <= PH_HOLD;
                                    endcase
                                end
                                default: begin
                                    cmd_valid <= 1'b1;
                                    cmd_data  <= rx_sh;
                                    phase     <= PH_HOLD;
                                end
                            endcase
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (tx_last) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_HOLD;
                            end else begin
                                sda_oe <= ~tx_next;
                            end
                        end
                    end
                    PH_STEP: begin
                        if (scl_rise) begin
                            step_armed <= 1'b1;
                            step_dir   <= sda_lvl;
                        end else if (scl_fall && step_armed) begin
                            step_valid <= 1'b1;
                            step_up    <= step_dir;
                            step_armed <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cmd_opcode = instr.opcode;
    assign cmd_reg    = instr.reg_sel;
    assign cmd_pot    = instr.pot_sel;

endmodule

// File: rtl/potbus_parser_chk.sv
module potbus_parser_chk
    import potbus_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scl_fall,
    input logic             sda_oe,
    input logic             cmd_valid,
    input logic [OPC_W-1:0] cmd_opcode,
    input logic             step_valid
);
    // R3
    cmd_defined_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (classify(cmd_opcode) != K_BAD));

    // R4
    cmd_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(scl_fall));

    // R4
    cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R7
    step_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        step_valid |-> $past(scl_fall));

    // R7
    step_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        step_valid |-> !cmd_valid);

    // R9
    oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

endmodule

bind potbus_frame_parser potbus_parser_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_fall   (scl_fall),
    .sda_oe     (sda_oe),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .step_valid (step_valid)
);

// File: tb/tb_potbus_frame_parser.sv
module tb_potbus_frame_parser;
    localparam int Q = 4;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] dev_addr = 4'hA;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] rd_data = 8'h00;
    logic       cmd_valid, step_valid, step_up;
    logic [3:0] cmd_opcode;
    logic [1:0] cmd_reg, cmd_pot;
    logic [7:0] cmd_data;

    int nchk = 0, nfail = 0;
    int ncmd = 0, nup = 0, ndn = 0;
    logic [3:0] last_op;
    logic [1:0] last_reg, last_pot;
    logic [7:0] last_data;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    potbus_frame_parser dut (
        .clk(clk), .rst(rst), .dev_addr(dev_addr),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_data(cmd_data),
        .step_valid(step_valid), .step_up(step_up)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                ncmd      <= ncmd + 1;
                last_op   <= cmd_opcode;
                last_reg  <= cmd_reg;
                last_pot  <= cmd_pot;
                last_data <= cmd_data;
            end
            if (step_valid) begin
                if (step_up) nup <= nup + 1;
                else         ndn <= ndn + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_kind(input logic [3:0] op);
        case (op)
            4'b1101, 4'b1110, 4'b0001, 4'b1000: return 1;
            4'b1010, 4'b1100:                   return 2;
            4'b1001, 4'b1011:                   return 3;
            4'b0010:                            return 4;
            default:                            return 0;
        endcase
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bit(input logic b);
        wait_clk(Q); sda_m = b;
        wait_clk(H); scl_m = 1'b1;
        wait_clk(H); scl_m = 1'b0;
    endtask

    task automatic slot(input logic drive, output logic seen);
        wait_clk(Q); sda_m = drive;
        wait_clk(H); scl_m = 1'b1;
        wait_clk(H / 2); seen = sda_line;
        wait_clk(H / 2); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        slot(1'b1, s);
        acked = ~s;
    endtask

    task automatic read_byte(output logic [7:0] b, output logic ack_slot);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, s);
            b[i] = s;
        end
        slot(1'b1, ack_slot);
    endtask

    task automatic do_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                            input int nsteps, input logic [15:0] dirs, input bit end_stop);
        logic a0, a1, a2, ackslot;
        logic [7:0] rb;
        bit exp0, exp1;
        int kind, c0, u0, d0, eu;
        exp0 = (b0[7:4] == 4'b0101) && (b0[3:0] == dev_addr);
        kind = exp_kind(b1[7:4]);
        exp1 = exp0 && (kind != 0);
        rd_data = b2;
        c0 = ncmd; u0 = nup; d0 = ndn;
        bus_start();
        send_byte(b0, a0);
        check(a0 == exp0, "R2 identity ack", a0, exp0);
        send_byte(b1, a1);
        check(a1 == exp1, "R3 instruction ack", a1, exp1);
        if (exp1 && kind == 2) begin
            send_byte(b2, a2);
            check(a2 == 1'b1, "R5 data ack", a2, 1);
        end
        if (exp1 && kind == 3) begin
            read_byte(rb, ackslot);
            check(rb == b2, "R6 read data", rb, b2);
            check(ackslot == 1'b1, "R11 master ack slot free", ackslot, 1);
        end
        eu = 0;
        if (exp1 && kind == 4) begin
            for (int i = 0; i < nsteps; i++) begin
                send_bit(dirs[i]);
                if (dirs[i]) eu++;
            end
        end
        if (end_stop) bus_stop();
        wait_clk(8);
        if (exp1 && kind == 4) begin
            check(nup - u0 == eu, "R7 R8 up steps", nup - u0, eu);
            check(ndn - d0 == nsteps - eu, "R7 R8 down steps", ndn - d0, nsteps - eu);
            check(ncmd == c0, "R7 no command in step mode", ncmd - c0, 0);
        end else if (exp1) begin
            check(ncmd == c0 + 1, "R4 one strobe", ncmd - c0, 1);
            check({last_op, last_reg, last_pot} == b1, "R4 fields", {last_op, last_reg, last_pot}, b1);
            if (kind == 2) check(last_data == b2, "R5 write data", last_data, b2);
        end else begin
            check(ncmd == c0, "R3 R2 no strobe", ncmd - c0, 0);
            check(nup == u0 && ndn == d0, "R3 R2 no step", nup + ndn - u0 - d0, 0);
        end
        if (end_stop) check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        logic a;
        logic [7:0] b0, b1, b2;
        seed = $urandom(32'h5EED);
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R10 reset state
        check(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
        check(cmd_valid == 1'b0, "R10 cmd_valid", cmd_valid, 0);
        check(step_valid == 1'b0, "R10 step_valid", step_valid, 0);

        // R4 transfer, R2 bad family, R2 bad address, R3 undefined opcode
        do_frame({4'b0101, dev_addr}, 8'b1101_10_01, 8'h00, 0, 16'h0, 1);
        do_frame({4'b0110, dev_addr}, 8'b1101_00_00, 8'h00, 0, 16'h0, 1);
        do_frame({4'b0101, 4'h3},     8'b0001_11_10, 8'h00, 0, 16'h0, 1);
        do_frame({4'b0101, dev_addr}, 8'b0111_01_01, 8'h00, 0, 16'h0, 1);
        // R5 write, R6 read with mixed bits
        do_frame({4'b0101, dev_addr}, 8'b1010_01_11, 8'hA5, 0, 16'h0, 1);
        do_frame({4'b0101, dev_addr}, 8'b1011_10_00, 8'h3C, 0, 16'h0, 1);
        // R7 steps ended by repeated start (R8), then frame parsed afresh (R1)
        do_frame({4'b0101, dev_addr}, 8'b0010_00_01, 8'h00, 7, 16'b0001011, 0);
        do_frame({4'b0101, dev_addr}, 8'b1110_01_10, 8'h00, 0, 16'h0, 1);
        // R8 steps ended by stop
        do_frame({4'b0101, dev_addr}, 8'b0010_00_10, 8'h00, 4, 16'b1001, 1);
        // R1 abort mid-byte then a full frame
        bus_start();
        send_byte({4'b0101, dev_addr}, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        do_frame({4'b0101, dev_addr}, 8'b1000_11_01, 8'h00, 0, 16'h0, 1);

        dev_addr = 4'h3;
        for (int n = 0; n < 48; n++) begin
            b0 = ($urandom % 4 != 0) ? {4'b0101, dev_addr} : 8'($urandom);
            b1 = 8'($urandom);
            b2 = 8'($urandom);
            do_frame(b0, b1, b2, $urandom % 6, 16'($urandom), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule